// File: doc/BRIEF.md
# Read-Only Memory Port with Read-Channel Back-Pressure

This block is a read-only slave that answers single-beat read requests from a small internal word array. The array stands in for an external memory during bring-up. A request comes in on the address channel: `s_arvalid`, `s_arready` and `s_araddr`, where the address is a word index. The answer goes out on the data channel: `s_rvalid`, `s_rready`, `s_rdata` and `s_rresp`. Both channels follow the usual valid/ready rule: a transfer takes place on a rising edge at which valid and ready are both high.

The block holds one answer at a time. Back-pressure is handled by refusing new requests rather than by buffering them. While an answer is presented and the master holds `s_rready` low, `s_arready` stays low, so no accepted request can be overwritten or dropped. As soon as the held answer is being taken, or no answer is held, `s_arready` is high. This allows one request and one answer per cycle when the master never stalls. `s_arready` is allowed to look at the data-channel state. `s_rvalid` never waits for `s_rready`.

The array contents are computed rather than loaded. Word `i` holds `(i * 32'h9E3779B1 + 32'h0F1E2D3C)` truncated to 32 bits.

Top module: `mem_read_port`

## Requirements
- R1: On the first cycle after a synchronous reset, `s_rvalid` is low and `s_arready` is high.
- R2: After an address handshake on edge k, `s_rvalid` is high from edge k onward whatever the level of `s_rready`. For an index below DEPTH (48), `s_rdata` is then `(index * 32'h9E3779B1 + 32'h0F1E2D3C) mod 2^32` and `s_rresp` is 2'b00 (OKAY).
- R3: A request whose index is DEPTH or higher returns `s_rdata` = 0 and `s_rresp` = 2'b10 (SLVERR).
- R4: While `s_rvalid` is high and `s_rready` is low, `s_rvalid`, `s_rdata` and `s_rresp` keep their values on the next edge.
- R5: While `s_rvalid` is high and `s_rready` is low, `s_arready` is low, and a pending `s_arvalid` is not accepted.
- R6: `s_arready` is high in every cycle where `s_rvalid` is low or `s_rready` is high. Back-to-back requests are then accepted on consecutive edges.
- R7: `s_rvalid` rises only on the edge after an address handshake. Every accepted request yields exactly one answer, and answers come in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_arvalid | input | 1 | Read request valid |
| s_arready | output | 1 | Read request accepted this edge if valid |
| s_araddr | input | ADDR_W (16) | Word index of the request |
| s_rvalid | output | 1 | Answer valid |
| s_rready | input | 1 | Master takes the answer this edge |
| s_rdata | output | DATA_W (32) | Answer word |
| s_rresp | output | 2 | 2'b00 OKAY, 2'b10 SLVERR |

## Verification
The bench holds `s_rready` low for several cycles while a second request waits. A slave that kept `s_arready` high would overwrite the held answer or lose a request, and the scoreboard would show missing or wrong data. It also watches the held beat cycle by cycle, to catch a design that lets `s_rdata` move or drops `s_rvalid` before the master takes it. Requests at index 47, 48, 63 and 16'hFFFF probe the edge of the non-power-of-two array: a decoder that wrapped or truncated the index would answer OKAY with array data. A randomly toggling `s_rready` mixed with back-to-back requests checks that no bubble is inserted and that answers stay in order.

// File: rtl/mem_read_port_pkg.sv
package mem_read_port_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } resp_e;

  localparam logic [31:0] FILL_MUL = 32'h9E3779B1;
  localparam logic [31:0] FILL_ADD = 32'h0F1E2D3C;

  // Content of array word idx
  function automatic logic [31:0] fill_word(input int unsigned idx);
    logic [31:0] w;
    w = idx;
    return w * FILL_MUL + FILL_ADD;
  endfunction

endpackage

// File: rtl/mem_read_port_store.sv
module mem_read_port_store
  import mem_read_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 48
) (
  input  logic [ADDR_W-1:0] look_addr,
  output logic [DATA_W-1:0] look_data,
  output logic              look_hit
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MEM_N = 1 << IDX_W;
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

  logic [DATA_W-1:0] words [MEM_N];

  for (genvar i = 0; i < MEM_N; i++) begin : g_word
    if (i < DEPTH) begin : g_used
      if (DATA_W <= 32) begin : g_narrow
        assign words[i] = fill_word(i)[DATA_W-1:0];
      end else begin : g_wide
        assign words[i] = {{(DATA_W-32){1'b0}}, fill_word(i)};
      end
    end else begin : g_spare
      assign words[i] = '0;
    end
  end

  logic [IDX_W-1:0] idx;
  assign idx       = look_addr[IDX_W-1:0];
  assign look_hit  = {1'b0, look_addr} < DEPTH_V;
  assign look_data = look_hit ? words[idx] : '0;

endmodule

// File: rtl/mem_read_port_gate.sv
module mem_read_port_gate (
  input  logic arvalid,
  input  logic rvalid,
  input  logic rready,
  output logic arready,
  output logic take,
  output logic drain
);
  // The answer slot is free, or is being emptied on this edge
  assign arready = !rvalid || rready;
  assign take    = arvalid && arready;
  assign drain   = rvalid && rready;
endmodule

// File: rtl/mem_read_port_slot.sv
module mem_read_port_slot
  import mem_read_port_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              drain,
  input  logic [DATA_W-1:0] load_data,
  input  resp_e             load_resp,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output resp_e             rresp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      rresp  <= RESP_OKAY;
    end else if (load) begin
      rvalid <= 1'b1;
      rdata  <= load_data;
      rresp  <= load_resp;
    end else if (drain) begin
      rvalid <= 1'b0;
    end
  end
endmodule

// File: rtl/mem_read_port.sv
module mem_read_port
  import mem_read_port_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_arvalid,
  output logic              s_arready,
  input  logic [ADDR_W-1:0] s_araddr,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp
);
  logic              take, drain, hit;
  logic [DATA_W-1:0] word;
  resp_e             resp_in, resp_q;

  mem_read_port_gate u_gate (
    .arvalid (s_arvalid),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .arready (s_arready),
    .take    (take),
    .drain   (drain)
  );

  mem_read_port_store #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_store (
    .look_addr (s_araddr),
    .look_data (word),
    .look_hit  (hit)
  );

  assign resp_in = hit ? RESP_OKAY : RESP_SLVERR;

  mem_read_port_slot #(
    .DATA_W (DATA_W)
  ) u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (take),
    .drain     (drain),
    .load_data (word),
    .load_resp (resp_in),
    .rvalid    (s_rvalid),
    .rdata     (s_rdata),
    .rresp     (resp_q)
  );

  assign s_rresp = resp_q;

endmodule

// File: rtl/mem_read_port_chk.sv
module mem_read_port_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 48
) (
  input logic              clk,
  input logic              rst,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [ADDR_W-1:0] s_araddr,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [1:0]        s_rresp
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(DEPTH);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (!s_rvalid && s_arready));

  // R2
  answer_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (s_arvalid && s_arready) |=> s_rvalid);

  // R3
  range_error_chk: assert property (@(posedge clk) disable iff (rst)
    (s_arvalid && s_arready && ({1'b0, s_araddr} >= DEPTH_V))
      |=> (s_rresp == 2'b10 && s_rdata == '0));

  // R4
  held_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));

  // R5
  stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (s_rvalid && !s_rready) |-> !s_arready);

  // R6
  free_accepts_chk: assert property (@(posedge clk) disable iff (rst)
    (!s_rvalid || s_rready) |-> s_arready);

  // R7
  rise_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(s_rvalid) |-> $past(s_arvalid && s_arready));

endmodule

bind mem_read_port mem_read_port_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH)
) u_chk (.*);

// File: tb/mem_read_port_test.sv
`timescale 1ns/1ps
module mem_read_port_test;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 48;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              s_arvalid = 1'b0;
  logic              s_arready;
  logic [ADDR_W-1:0] s_araddr = '0;
  logic              s_rvalid;
  logic              s_rready = 1'b1;
  logic [DATA_W-1:0] s_rdata;
  logic [1:0]        s_rresp;

  always #4 clk = ~clk;

  mem_read_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) uut (.*);

  int checks = 0;
  int errors = 0;
  int issued = 0;
  int beats  = 0;
  int rmode  = 0;           // 0 ready high, 1 random, 2 held low
  logic [15:0] lfsr = 16'hACE1;
  logic [33:0] expq [$];    // {resp, data}
  logic        done = 1'b0;

  function automatic logic [33:0] expect_of(input logic [ADDR_W-1:0] a);
    if (a < DEPTH) return {2'b00, (32'(a) * 32'h9E3779B1 + 32'h0F1E2D3C)};
    return {2'b10, 32'h0};
  endfunction

  task automatic check(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Driver: hold request until accepted, then push the expected answer
  task automatic issue(input logic [ADDR_W-1:0] a);
    s_arvalid = 1'b1;
    s_araddr  = a;
    do @(negedge clk); while (!s_arready);
    expq.push_back(expect_of(a));
    issued++;
    @(posedge clk);
    #1;
    // R2: answer is up on the next edge whatever s_rready is
    check(s_rvalid === 1'b1, "R2 rvalid after handshake", 64'(s_rvalid), 64'd1);
    s_arvalid = 1'b0;
  endtask

  // s_rready pattern generator
  initial begin
    forever begin
      @(posedge clk);
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (rmode)
        0: s_rready = 1'b1;
        1: s_rready = lfsr[0];
        default: s_rready = 1'b0;
      endcase
    end
  end

  // Monitor / scoreboard
  logic        held = 1'b0;
  logic [33:0] held_val;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (held)  // R4
          check(s_rvalid && {s_rresp, s_rdata} === held_val, "R4 held beat stable",
                64'({s_rresp, s_rdata}), 64'(held_val));
        if (s_rvalid && !s_rready)  // R5
          check(s_arready == 1'b0, "R5 arready low on stall", 64'(s_arready), 64'd0);
        else  // R6
          check(s_arready == 1'b1, "R6 arready high when free", 64'(s_arready), 64'd1);
        held     = s_rvalid && !s_rready;
        held_val = {s_rresp, s_rdata};
        if (s_rvalid && s_rready) begin
          beats++;
          if (expq.size() == 0)
            check(1'b0, "R7 beat without request", 64'(s_rdata), 64'd0);
          else begin
            logic [33:0] e;
            e = expq.pop_front();
            // R2 / R3: content and response in request order (R7)
            check({s_rresp, s_rdata} === e, (e[33:32] == 2'b10) ? "R3 range error" : "R2 R7 data",
                  64'({s_rresp, s_rdata}), 64'(e));
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 64'(issued), 64'(beats));
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    check(!s_rvalid && s_arready, "R1 reset state", 64'({s_rvalid, s_arready}), 64'b01);
    @(posedge clk); #1;

    // back-to-back in range, ready high
    issue(16'd0); issue(16'd1); issue(16'd47); issue(16'd23);
    // out of range R3
    issue(16'd48); issue(16'd63); issue(16'hFFFF);

    // stall: ready held low, second request must wait (R5)
    fork
      begin
        rmode = 2;
        repeat (7) @(posedge clk);
        rmode = 0;
      end
    join_none
    @(posedge clk); #1;
    issue(16'd5); issue(16'd6); issue(16'd64);

    // random back-pressure
    rmode = 1;
    for (int i = 0; i < 40; i++) issue(16'((i * 7 + 3) % 70));
    rmode = 0;
    repeat (6) @(posedge clk);
    #1;
    // R7: one answer per request
    check(expq.size() == 0 && beats == issued, "R7 answer count",
          64'(beats), 64'(issued));
    finish_run();
  end
endmodule